// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a word-at-a-time SPI master that sits on a simple memory-mapped register bus and drives one slave device. Software selects the word size and the serial clock rate in a configuration register. It controls the chip select through a control bit. Writing the transmit-data register starts one full-duplex exchange. When the exchange finishes, a completion flag appears in the cause register. Software then reads the received word and clears the flag before it starts the next word.

The serial clock is derived from the system clock by an even divider set through a 5-bit code. The link runs in SPI mode 0 only: the clock idles low, data is sampled on the rising edge and driven after the falling edge. Every exchange clocks out a whole word, including a zero word, so a read with no real transmit data is also a write of zero. The bus read path is combinational on the address.

Top module: `spim_top`

## Requirements
- R1: After reset the chip select output `spi_cs_n` is high (deasserted), `spi_sck` is low, and every register reads zero.
- R2: Writing the control register at offset 0x00 with bit 0 set drives `spi_cs_n` low from the next cycle. Writing bit 0 clear drives it high. The control register reads back bit 0 only.
- R3: The configuration register at offset 0x04 holds the word size in bit 5 (1 = 16 bits, 0 = 8 bits) and the rate code in bits [4:0]. An exchange gives exactly 8 or 16 SCK pulses. The size and rate are taken at the start of each exchange.
- R4: SCK idles low. During an exchange its high and low phases each last (code − 16) system clocks, so the period is 2·(code − 16) clocks, from 4 (code 0x12) to 30 (code 0x1F).
- R5: A write to offset 0x08 while idle starts an exchange. MOSI carries the word MSB first (bit 7 of the written value in 8-bit mode, bit 15 in 16-bit mode), is stable at each rising SCK edge and moves only after a falling edge. A written value of zero still clocks a full word.
- R6: Bit 0 of the cause register at offset 0x10 becomes 1 on the clock that ends the final SCK high phase. Any write to offset 0x10 clears it. A completion in the same cycle as a clearing write wins.
- R7: A rate code below 0x12 acts as 0x12, giving a divide ratio of 4.
- R8: A write to offset 0x08 while an exchange is in progress is ignored. The exchange under way keeps its data, size and length, and no second exchange follows.
- R9: MISO is sampled on each rising SCK edge. The first bit becomes the MSB of the received word (bit 7 or bit 15), and the word is zero-extended in the data-in register at offset 0x0C. That register changes only when an exchange completes.
- R10: Reads return zero in all unused bits. Offset 0x08 and unmapped offsets read zero. The configuration register reads back its six bits exactly as written, unclamped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, 5-bit offsets, 16-bit maximum word and a 5-bit rate code. This covers both word sizes, the fastest ratio (4), the slowest ratio (30) and an in-between ratio. The clamp on codes below 0x12 and an intruding data-out write during an exchange are also exercised. A behavioural slave measures the SCK period, counts pulses and collects MOSI. Expected items go into a queue and are compared against the received word, the pulse count and the measured period.

// File: rtl/spim_pkg.sv
// Package: shared offsets and widths for the SPI master.
// Assumes byte offsets on a 32-bit word-aligned register bus.
package spim_pkg;
    localparam int unsigned ADDR_W    = 5;
    localparam int unsigned CODE_W    = 5;
    localparam int unsigned MAX_BITS  = 16;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CFG   = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_DOUT  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_DIN   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_CAUSE = 5'h10;

    localparam logic [CODE_W-1:0] CODE_BASE = 5'h10;
    localparam logic [CODE_W-1:0] CODE_MIN  = 5'h12;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_CFG, SEL_DOUT, SEL_DIN, SEL_CAUSE
    } reg_sel_e;

    // Decode a bus offset into a register select.
    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_CTRL:  return SEL_CTRL;
            OFF_CFG:   return SEL_CFG;
            OFF_DOUT:  return SEL_DOUT;
            OFF_DIN:   return SEL_DIN;
            OFF_CAUSE: return SEL_CAUSE;
            default:   return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/spim_clkdiv.sv
// Module: spim_clkdiv
// Produces a one-cycle tick every HALF system clocks while run is high.
// Assumes half >= 2 and stays fixed while run is high.
module spim_clkdiv #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == half - CNT_W'(1));
    assign tick   = run && at_end;

    // Count system clocks within one SCK phase, restarting when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (at_end)    cnt_q <= '0;
        else                cnt_q <= cnt_q + CNT_W'(1);
    end

    // R4: the phase counter never passes the phase length
    a_r4_cnt_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < half));
endmodule

// File: rtl/spim_shift.sv
// Module: spim_shift
// Mode-0 shift engine: one word per start, MSB first, SCK idle low.
// Assumes tick comes from a divider that runs while busy is high.
module spim_shift #(
    parameter int unsigned MAX_BITS = 16,
    parameter int unsigned CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                wide_in,
    input  logic [CNT_W-1:0]    half_in,
    input  logic [MAX_BITS-1:0] tx_in,
    input  logic                tick,
    input  logic                miso,
    output logic                busy,
    output logic [CNT_W-1:0]    half_act,
    output logic                sck,
    output logic                mosi,
    output logic                done,
    output logic [MAX_BITS-1:0] rx_word
);
    localparam int unsigned LOW_BITS = MAX_BITS / 2;
    localparam int unsigned BCNT_W   = $clog2(MAX_BITS + 1);

    logic                busy_q, sck_q, wide_q;
    logic [CNT_W-1:0]    half_q;
    logic [MAX_BITS-1:0] tx_sh, rx_sh;
    logic [BCNT_W-1:0]   bits_q, nbits;

    assign nbits    = wide_q ? BCNT_W'(MAX_BITS) : BCNT_W'(LOW_BITS);
    assign busy     = busy_q;
    assign half_act = half_q;
    assign sck      = sck_q;
    assign mosi     = tx_sh[MAX_BITS-1];
    assign done     = busy_q && tick && sck_q && (bits_q == nbits);
    assign rx_word  = wide_q ? rx_sh : {{LOW_BITS{1'b0}}, rx_sh[LOW_BITS-1:0]};

    // Load a word on start, then toggle SCK on each tick, sampling on rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            wide_q <= 1'b0;
            half_q <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            bits_q <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
            wide_q <= wide_in;
            half_q <= half_in;
            tx_sh  <= wide_in ? tx_in : {tx_in[LOW_BITS-1:0], {LOW_BITS{1'b0}}};
            rx_sh  <= '0;
            bits_q <= '0;
        end else if (busy_q && tick) begin
            if (!sck_q) begin
                sck_q  <= 1'b1;
                rx_sh  <= {rx_sh[MAX_BITS-2:0], miso};
                bits_q <= bits_q + BCNT_W'(1);
            end else begin
                sck_q <= 1'b0;
                if (bits_q == nbits) busy_q <= 1'b0;
                else                 tx_sh  <= {tx_sh[MAX_BITS-2:0], 1'b0};
            end
        end
    end

    // R4: SCK stays low whenever no exchange runs
    a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sck_q);
    // R5: MOSI does not move on the cycle SCK rises
    a_r5_mosi_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_q) |-> $stable(mosi));
    // R3: never more pulses than the word size
    a_r3_bits_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q <= nbits);
    // R8: a start during an exchange leaves the latched size alone
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> $stable(wide_q) && $stable(half_q));
    // R6: completion ends the exchange with SCK low
    a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy_q && !sck_q));
endmodule

// File: rtl/spim_regs.sv
// Module: spim_regs
// Register file: control, configuration, data out (write-only), data in,
// completion cause. Reads are combinational on the address.
module spim_regs
    import spim_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned MAX_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                done,
    input  logic [MAX_BITS-1:0] rx_word,
    output logic                cs_on,
    output logic                cfg_wide,
    output logic [CODE_W-1:0]   cfg_code,
    output logic                start,
    output logic [MAX_BITS-1:0] tx_word
);
    reg_sel_e            sel;
    logic                ctrl_q, wide_q, cause_q;
    logic [CODE_W-1:0]   code_q;
    logic [MAX_BITS-1:0] din_q;

    assign sel      = decode(bus_addr);
    assign cs_on    = ctrl_q;
    assign cfg_wide = wide_q;
    assign cfg_code = code_q;
    assign start    = bus_wr && (sel == SEL_DOUT);
    assign tx_word  = bus_wdata[MAX_BITS-1:0];

    // Control and configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
            wide_q <= 1'b0;
            code_q <= '0;
        end else if (bus_wr && sel == SEL_CTRL) begin
            ctrl_q <= bus_wdata[0];
        end else if (bus_wr && sel == SEL_CFG) begin
            wide_q <= bus_wdata[CODE_W];
            code_q <= bus_wdata[CODE_W-1:0];
        end
    end

    // Completion flag: set by the engine, cleared by any cause write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cause_q <= 1'b0;
        else if (done)                       cause_q <= 1'b1;
        else if (bus_wr && sel == SEL_CAUSE) cause_q <= 1'b0;
    end

    // Received word capture at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)    din_q <= '0;
        else if (done) din_q <= rx_word;
    end

    // Read mux with zero fill.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL:  bus_rdata[0] = ctrl_q;
            SEL_CFG:   bus_rdata[CODE_W:0] = {wide_q, code_q};
            SEL_DIN:   bus_rdata[MAX_BITS-1:0] = din_q;
            SEL_CAUSE: bus_rdata[0] = cause_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R6: a completion always leaves the flag set
    a_r6_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cause_q);
    // R9: the received word only changes on completion
    a_r9_din_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(din_q));
    // R2: control bit follows the written value
    a_r2_ctrl_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_CTRL) |=> (ctrl_q == $past(bus_wdata[0])));
endmodule

// File: rtl/spim_top.sv
// Module: spim_top
// Single-slave mode-0 SPI master on a memory-mapped register bus.
// Assumes one register access per cycle and a free-running system clock.
module spim_top
    import spim_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    localparam int unsigned CNT_W = CODE_W - 1;

    logic                cs_on, cfg_wide, start, busy, tick, done;
    logic [CODE_W-1:0]   cfg_code, eff_code, half_full;
    logic [CNT_W-1:0]    half_req, half_act;
    logic [MAX_BITS-1:0] tx_word, rx_word;

    // Clamp the rate code to the fastest legal ratio and form the phase length.
    assign eff_code  = (cfg_code < CODE_MIN) ? CODE_MIN : cfg_code;
    assign half_full = eff_code - CODE_BASE;
    assign half_req  = half_full[CNT_W-1:0];
    assign spi_cs_n  = !cs_on;

    spim_regs #(.DATA_W(DATA_W), .MAX_BITS(MAX_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done),
        .rx_word(rx_word), .cs_on(cs_on), .cfg_wide(cfg_wide),
        .cfg_code(cfg_code), .start(start), .tx_word(tx_word)
    );

    spim_clkdiv #(.CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .half(half_act), .tick(tick)
    );

    spim_shift #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_in(cfg_wide),
        .half_in(half_req), .tx_in(tx_word), .tick(tick), .miso(spi_miso),
        .busy(busy), .half_act(half_act), .sck(spi_sck), .mosi(spi_mosi),
        .done(done), .rx_word(rx_word)
    );

    // R7: the phase length used is never below two clocks
    a_r7_min_phase: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (half_act >= CNT_W'(2)));
endmodule

// File: tb/spim_top_tb.sv
module spim_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_cs_n;
    logic        spi_miso;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    typedef struct {
        logic [15:0] rx;
        logic [15:0] mosi;
        int          pulses;
        int          period;
    } item_t;
    item_t exp_q[$];
    item_t act_q[$];

    // slave model state
    logic [15:0] slv_sh = '0;
    logic [15:0] mosi_cap = '0;
    int          rises = 0;
    int          last_rise = 0;
    int          per_seen = 0;

    spim_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always #10 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    assign spi_miso = slv_sh[15];
    always @(posedge spi_sck) begin
        mosi_cap  = {mosi_cap[14:0], spi_mosi};
        if (rises > 0) per_seen = cyc - last_rise;
        last_rise = cyc;
        rises     = rises + 1;
    end
    always @(negedge spi_sck) slv_sh = {slv_sh[14:0], 1'b0};

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    // Driver: configure, push expectation, run one word, push observation.
    task automatic xfer(input bit wide, input logic [4:0] code, input logic [15:0] tx,
                        input logic [15:0] slv, input bit intrude);
        item_t e, a;
        logic [31:0] v;
        int h, guard;
        h = (code < 5'h12) ? 2 : int'(code) - 16;
        e.rx     = wide ? slv : {8'h00, slv[7:0]};
        e.mosi   = wide ? tx  : {8'h00, tx[7:0]};
        e.pulses = wide ? 16 : 8;
        e.period = 2 * h;
        exp_q.push_back(e);
        wr(5'h04, {26'd0, wide, code});
        wr(5'h10, 32'h0);
        slv_sh = wide ? slv : {slv[7:0], 8'h00};
        mosi_cap = '0; rises = 0; per_seen = 0;
        wr(5'h08, {16'hDEAD, tx});
        if (intrude) begin
            repeat (5) @(negedge clk);
            wr(5'h08, 32'h0000_3C3C);
        end
        guard = 0;
        v = 0;
        while (v[0] == 1'b0 && guard < 2000) begin
            rd(5'h10, v);
            guard++;
        end
        rd(5'h0C, v);
        a.rx = v[15:0]; a.mosi = mosi_cap; a.pulses = rises; a.period = per_seen;
        act_q.push_back(a);
        // R8: no second exchange follows an ignored write
        repeat (40) @(negedge clk);
        check(rises == e.pulses, "R8 no extra pulses", rises, e.pulses);
    endtask

    // Monitor: compare observations against expectations in order.
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                item_t e, a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                check(a.rx == e.rx, "R9 received word", a.rx, e.rx);
                check(a.mosi == e.mosi, "R5 MOSI word", a.mosi, e.mosi);
                check(a.pulses == e.pulses, "R3 pulse count", a.pulses, e.pulses);
                check(a.period == e.period, "R4 R7 SCK period", a.period, e.period);
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #2;
        check(spi_cs_n == 1'b1, "R1 cs deasserted", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1 sck low", spi_sck, 0);
        rd(5'h00, v); check(v == 0, "R1 ctrl zero", v, 0);
        rd(5'h04, v); check(v == 0, "R1 cfg zero", v, 0);
        rd(5'h0C, v); check(v == 0, "R1 din zero", v, 0);
        rd(5'h10, v); check(v == 0, "R1 cause zero", v, 0);
        // R2 chip select
        wr(5'h00, 32'hFFFF_FFFF);
        #2 check(spi_cs_n == 1'b0, "R2 cs asserted", spi_cs_n, 0);
        rd(5'h00, v); check(v == 1, "R2 ctrl readback", v, 1);
        // R10 readback and zero fill
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, v); check(v == 32'h3F, "R10 cfg readback", v, 32'h3F);
        rd(5'h08, v); check(v == 0, "R10 data-out reads zero", v, 0);
        rd(5'h14, v); check(v == 0, "R10 unmapped zero", v, 0);
        // exchanges
        xfer(1'b0, 5'h12, 16'h00A5, 16'h003C, 1'b0);
        xfer(1'b1, 5'h1F, 16'hC3E1, 16'h9A5B, 1'b0);
        xfer(1'b0, 5'h05, 16'h005A, 16'h0081, 1'b0);   // R7 clamp
        xfer(1'b0, 5'h15, 16'h0000, 16'h00E7, 1'b0);   // R5 zero still clocks
        xfer(1'b1, 5'h13, 16'h8001, 16'h7FFE, 1'b1);   // R8 intruding write
        xfer(1'b0, 5'h14, 16'h00F0, 16'h0042, 1'b1);
        // R6 clear, R9 hold
        rd(5'h10, v); check(v == 1, "R6 flag still set", v, 1);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10, v); check(v == 0, "R6 flag cleared", v, 0);
        wr(5'h04, 32'h3F);
        rd(5'h0C, v); check(v == 32'h42, "R9 din held", v, 32'h42);
        check(spi_sck == 1'b0, "R4 sck idle low", spi_sck, 0);
        wr(5'h00, 32'h0);
        #2 check(spi_cs_n == 1'b1, "R2 cs released", spi_cs_n, 1);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 all items compared", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule